// File: doc/BRIEF.md
# Third-Order Cascaded Integrator-Comb Decimator

This block turns the single-bit stream from a sigma-delta modulator into 15-bit parallel samples at a lower rate. Each modulator bit is qualified by an enable pulse. A bit of 1 counts as +1 and a bit of 0 counts as −1. Three running-sum stages accumulate every accepted bit. A down-counter-free modulo counter marks every N-th accepted bit. At that mark, three differencing stages form the filtered sum. The response is the cube of an N-tap boxcar, which gives a gain of N³. The result is then shifted and clipped to a 15-bit two's-complement word.

A 2-bit rate code picks N at run time. Code 0 gives 32, 1 gives 64, 2 gives 128 and 3 gives 256. The shift grows with N, so full scale always lands at the edge of the 15-bit range. When the code changes, the block restarts its decimation phase and its differencing history. It then marks its first few outputs as not yet settled, so the consumer can discard them.

Top module: `cic3_decimator`

## Requirements
- R1: While `rst_n` is low at a clock edge, the edge leaves `sample_valid` at 0, `sample_out` at 0 and `sample_settled` at 0.
- R2: A bit is accepted only in a cycle with `bit_en` high. `bit_in` = 1 adds +1 and `bit_in` = 0 adds −1. `bit_in` has no effect in cycles with `bit_en` low.
- R3: The decimation factor N is 32 << `rate_sel` (code 0 → 32, 1 → 64, 2 → 128, 3 → 256). Between restarts, exactly one `sample_valid` pulse appears per N accepted bits. Each pulse lasts a single clock.
- R4: `sample_out` is the two's-complement value of the N³-gain filter result shifted right arithmetically by 3·log2(N) − 14. An input with density 3/4 ones gives +8192 at every N. An input with density 5/8 ones gives +4096. An alternating input gives 0.
- R5: Results beyond the 15-bit range clip. An all-ones input gives 16383 at every N. An all-zeros input gives −16384.
- R6: A rate change is detected at the first clock edge where `rate_sel` differs from its value at the previous edge. That edge clears the decimation count and the differencing history. It also discards any result not yet presented, so no `sample_valid` follows in the next cycle. A bit accepted in that same cycle still enters the running sums but is not counted toward the next output.
- R7: `sample_settled` is 0 on the first three outputs after reset or after a rate change, and 1 on every later output.
- R8: When a rate change is detected in the same cycle as the bit that would complete a decimation period, the restart wins. No output is produced for that period, and the next output comes N (new rate) bits later.
- R9: `sample_out` and `sample_settled` change only in a cycle where `sample_valid` is high. They hold between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Qualifies `bit_in` at the modulator rate |
| bit_in | input | 1 | Modulator bit, 1 = +1, 0 = −1 |
| rate_sel | input | 2 | Decimation code, N = 32 << code |
| sample_out | output | 15 | Scaled, clipped two's-complement sample |
| sample_valid | output | 1 | One-clock strobe marking a new sample |
| sample_settled | output | 1 | High when the sample is past the restart transient |

## Verification
Two functions can fall in the same cycle: the bit that completes a decimation period, and the detection of a new rate code. The bench provokes this by ending one segment a single bit short of a whole period. It then changes `rate_sel` on the same edge that delivers the next bit. The scoreboard expects no output for the lost period. It expects the next three outputs at the new rate to be unsettled, and the settled values after them to match the new pattern. Any extra or missing pulse shows up as a mismatch in pulse count or in order.

// File: rtl/cic3_pkg.sv
// Shared constants and helpers for the CIC decimator.
// Assumes a cascade of equal-length boxcars; STAGES sets the filter order.
package cic3_pkg;
    localparam int STAGES      = 3;  // integrator/comb pairs
    localparam int SETTLE_LEN  = 3;  // outputs flagged unsettled after restart

    // Right-shift that maps a gain of 2^(STAGES*log2n) onto out_w bits.
    function automatic int scale_shift(input int log2n, input int out_w);
        return STAGES * log2n + 1 - out_w;
    endfunction
endpackage

// File: rtl/cic3_integrators.sv
// Cascade of running-sum stages clocked by the modulator enable.
// Assumes modular (wrap-around) two's-complement arithmetic; the comb
// differences recover exact results as long as ACC_W covers the gain.
module cic3_integrators
    import cic3_pkg::*;
#(
    parameter int ACC_W = 26
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bit_en,
    input  logic                    bit_in,
    output logic signed [ACC_W-1:0] sum_out
);
    logic signed [ACC_W-1:0] stage_q [STAGES];
    logic signed [ACC_W-1:0] unit_in;

    // Map the modulator bit onto +1 / -1.
    always_comb unit_in = bit_in ? ACC_W'(1) : {ACC_W{1'b1}};

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W-1:0] feed;

        if (k == 0) begin : g_first
            assign feed = unit_in;
        end else begin : g_next
            assign feed = stage_q[k-1];
        end

        // Accumulate the previous stage once per accepted modulator bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc <= '0;
            end else if (bit_en) begin
                acc <= acc + feed;
            end
        end

        assign stage_q[k] = acc;
    end

    assign sum_out = stage_q[STAGES-1];
endmodule

// File: rtl/cic3_rate_ctrl.sv
// Rate tracking and decimation phase for the CIC decimator.
// Detects a change of the rate code by comparing against the code seen at
// the previous edge; a change restarts the phase and the settle count.
// Assumes the rate code is synchronous to clk.
module cic3_rate_ctrl
    import cic3_pkg::*;
#(
    parameter int RATE_W    = 2,
    parameter int BASE_LOG2 = 5,
    parameter int CNT_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [RATE_W-1:0] rate_sel,
    output logic [RATE_W-1:0] rate_cur,
    output logic              restart,
    output logic              strobe,
    output logic              strobe_settled
);
    localparam int SET_W = $clog2(SETTLE_LEN + 1);

    logic [RATE_W-1:0] rate_q;
    logic [CNT_W-1:0]  phase_q;
    logic [CNT_W:0]    period;
    logic [CNT_W-1:0]  last_phase;
    logic [SET_W-1:0]  settle_q;
    logic              at_end;

    // Terminal phase value for the active decimation factor.
    always_comb begin
        period     = (CNT_W+1)'(1) << (BASE_LOG2 + int'(rate_q));
        last_phase = CNT_W'(period - 1'b1);
    end

    // Restart request and end-of-period strobe; a restart wins a tie.
    always_comb begin
        restart = (rate_sel != rate_q);
        at_end  = bit_en && (phase_q == last_phase);
        strobe  = at_end && !restart;
    end

    // Track the code, advance the phase and count outputs since restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q   <= rate_sel;
            phase_q  <= '0;
            settle_q <= '0;
        end else begin
            rate_q <= rate_sel;
            if (restart) begin
                phase_q  <= '0;
                settle_q <= '0;
            end else if (bit_en) begin
                phase_q <= at_end ? '0 : phase_q + 1'b1;
                if (at_end && settle_q != SET_W'(SETTLE_LEN)) begin
                    settle_q <= settle_q + 1'b1;
                end
            end
        end
    end

    assign rate_cur       = rate_q;
    assign strobe_settled = (settle_q == SET_W'(SETTLE_LEN));
endmodule

// File: rtl/cic3_combs.sv
// Differencing stages at the decimated rate.
// On each strobe, all stages are evaluated in one cycle and the history is
// advanced. A restart clears the history and drops any pending result.
module cic3_combs
    import cic3_pkg::*;
#(
    parameter int ACC_W = 26
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    restart,
    input  logic                    strobe,
    input  logic                    strobe_settled,
    input  logic signed [ACC_W-1:0] sum_in,
    output logic signed [ACC_W-1:0] comb_out,
    output logic                    comb_valid,
    output logic                    comb_settled
);
    logic signed [ACC_W-1:0] diff [STAGES+1];

    assign diff[0] = sum_in;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        logic signed [ACC_W-1:0] hist;

        assign diff[k+1] = diff[k] - hist;

        // Remember this stage's input from the previous decimated sample.
        always_ff @(posedge clk) begin
            if (!rst_n || restart) begin
                hist <= '0;
            end else if (strobe) begin
                hist <= diff[k];
            end
        end
    end

    // Register the final difference with its valid and settle tag.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            comb_out     <= '0;
            comb_valid   <= 1'b0;
            comb_settled <= 1'b0;
        end else begin
            comb_valid <= strobe;
            if (strobe) begin
                comb_out     <= diff[STAGES];
                comb_settled <= strobe_settled;
            end
        end
    end
endmodule

// File: rtl/cic3_scaler.sv
// Scales the full-gain result to OUT_W bits and clips it.
// The shift depends on the active rate code, so full scale fills OUT_W
// bits at every factor. Assumes the rate code cannot change under a
// pending result (a restart discards it).
module cic3_scaler
    import cic3_pkg::*;
#(
    parameter int ACC_W     = 26,
    parameter int OUT_W     = 15,
    parameter int RATE_W    = 2,
    parameter int BASE_LOG2 = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    restart,
    input  logic [RATE_W-1:0]       rate_cur,
    input  logic                    in_valid,
    input  logic                    in_settled,
    input  logic signed [ACC_W-1:0] in_sample,
    output logic [OUT_W-1:0]        sample_out,
    output logic                    sample_valid,
    output logic                    sample_settled
);
    localparam logic signed [ACC_W-1:0] HI_LIM = ACC_W'((1 <<< (OUT_W-1)) - 1);
    localparam logic signed [ACC_W-1:0] LO_LIM = -ACC_W'(1 <<< (OUT_W-1));

    int                      shamt;
    logic signed [ACC_W-1:0] shifted;
    logic [OUT_W-1:0]        clipped;

    // Rate-dependent arithmetic shift followed by clipping.
    always_comb begin
        shamt   = scale_shift(BASE_LOG2 + int'(rate_cur), OUT_W);
        shifted = in_sample >>> shamt;
        if (shifted > HI_LIM) begin
            clipped = HI_LIM[OUT_W-1:0];
        end else if (shifted < LO_LIM) begin
            clipped = LO_LIM[OUT_W-1:0];
        end else begin
            clipped = shifted[OUT_W-1:0];
        end
    end

    // Present a new word only with its one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_out     <= '0;
            sample_valid   <= 1'b0;
            sample_settled <= 1'b0;
        end else begin
            sample_valid <= in_valid && !restart;
            if (in_valid && !restart) begin
                sample_out     <= clipped;
                sample_settled <= in_settled;
            end
        end
    end
endmodule

// File: rtl/cic3_decimator.sv
// Third-order CIC decimator: 1-bit modulator stream in, 15-bit samples out.
// The decimation factor is 2^(BASE_LOG2 + rate_sel), selectable at run time.
// Assumes bit_en pulses at most once per clock and rate_sel is synchronous.
module cic3_decimator
    import cic3_pkg::*;
#(
    parameter int BASE_LOG2 = 5,
    parameter int RATE_W    = 2,
    parameter int OUT_W     = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic [RATE_W-1:0] rate_sel,
    output logic [OUT_W-1:0]  sample_out,
    output logic              sample_valid,
    output logic              sample_settled
);
    localparam int MAX_LOG2 = BASE_LOG2 + (1 << RATE_W) - 1;
    localparam int ACC_W    = STAGES * MAX_LOG2 + 2;
    localparam int CNT_W    = MAX_LOG2;

    logic signed [ACC_W-1:0] sum_w;
    logic signed [ACC_W-1:0] comb_w;
    logic [RATE_W-1:0]       rate_cur;
    logic                    restart;
    logic                    strobe;
    logic                    strobe_settled;
    logic                    comb_valid;
    logic                    comb_settled;

    cic3_integrators #(.ACC_W(ACC_W)) u_integ (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .bit_in  (bit_in),
        .sum_out (sum_w)
    );

    cic3_rate_ctrl #(
        .RATE_W    (RATE_W),
        .BASE_LOG2 (BASE_LOG2),
        .CNT_W     (CNT_W)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .bit_en         (bit_en),
        .rate_sel       (rate_sel),
        .rate_cur       (rate_cur),
        .restart        (restart),
        .strobe         (strobe),
        .strobe_settled (strobe_settled)
    );

    cic3_combs #(.ACC_W(ACC_W)) u_combs (
        .clk            (clk),
        .rst_n          (rst_n),
        .restart        (restart),
        .strobe         (strobe),
        .strobe_settled (strobe_settled),
        .sum_in         (sum_w),
        .comb_out       (comb_w),
        .comb_valid     (comb_valid),
        .comb_settled   (comb_settled)
    );

    cic3_scaler #(
        .ACC_W     (ACC_W),
        .OUT_W     (OUT_W),
        .RATE_W    (RATE_W),
        .BASE_LOG2 (BASE_LOG2)
    ) u_scale (
        .clk            (clk),
        .rst_n          (rst_n),
        .restart        (restart),
        .rate_cur       (rate_cur),
        .in_valid       (comb_valid),
        .in_settled     (comb_settled),
        .in_sample      (comb_w),
        .sample_out     (sample_out),
        .sample_valid   (sample_valid),
        .sample_settled (sample_settled)
    );
endmodule

// File: rtl/cic3_decimator_chk.sv
// Port-level properties of the CIC decimator, bound to every instance.
// Keeps its own copy of the rate code and an output count since restart.
module cic3_decimator_chk #(
    parameter int RATE_W = 2,
    parameter int OUT_W  = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic [RATE_W-1:0] rate_sel,
    input logic [OUT_W-1:0]  sample_out,
    input logic              sample_valid,
    input logic              sample_settled
);
    logic [RATE_W-1:0] code_seen;
    logic [1:0]        outs_seen;
    logic              code_moved;

    assign code_moved = (rate_sel != code_seen);

    // Outputs presented since the last reset or code change, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_seen <= rate_sel;
            outs_seen <= '0;
        end else begin
            code_seen <= rate_sel;
            if (code_moved) begin
                outs_seen <= '0;
            end else if (sample_valid && outs_seen != 2'd3) begin
                outs_seen <= outs_seen + 1'b1;
            end
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!sample_valid && sample_out == '0 && !sample_settled));

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    assert_restart_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        code_moved |=> !sample_valid);

    assert_settle_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (sample_settled == (outs_seen == 2'd3)));

    assert_hold_between_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> ($stable(sample_out) && $stable(sample_settled)));
endmodule

bind cic3_decimator cic3_decimator_chk #(
    .RATE_W (RATE_W),
    .OUT_W  (OUT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rate_sel       (rate_sel),
    .sample_out     (sample_out),
    .sample_valid   (sample_valid),
    .sample_settled (sample_settled)
);

// File: tb/cic3_decimator_bench.sv
// Scoreboard bench: segment driver queues expected outputs, monitor compares.
module cic3_decimator_bench;
    localparam int GAP      = 4;
    localparam int WATCHDOG = 200000;

    typedef struct {
        bit    settled;
        int    value;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        bit_in = 1'b0;
    logic [1:0]  rate_sel = 2'd0;
    logic [14:0] sample_out;
    logic        sample_valid;
    logic        sample_settled;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails = 0;
    int   pushed = 0;
    int   seen = 0;
    bit   done = 1'b0;
    bit   prev_valid = 1'b0;

    always #5 clk = ~clk;

    cic3_decimator u_cic3_decimator (
        .clk            (clk),
        .rst_n          (rst_n),
        .bit_en         (bit_en),
        .bit_in         (bit_in),
        .rate_sel       (rate_sel),
        .sample_out     (sample_out),
        .sample_valid   (sample_valid),
        .sample_settled (sample_settled)
    );

    function automatic bit pat_bit(input int pat, input int idx);
        case (pat)
            0: return 1'b1;
            1: return 1'b0;
            2: return (idx % 4) != 3;
            3: return (idx % 4) == 0;
            4: return 1'((idx % 2));
            default: return (idx % 8) < 5;
        endcase
    endfunction

    function automatic int pat_value(input int pat);
        case (pat)
            0: return 16383;
            1: return -16384;
            2: return 8192;
            3: return -8192;
            4: return 0;
            default: return 4096;
        endcase
    endfunction

    task automatic check(input bit ok, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
        end
    endtask

    // One accepted bit, then GAP-1 idle cycles with junk on bit_in (R2).
    task automatic send_bit(input bit b, input bit set_code, input logic [1:0] code);
        @(negedge clk);
        bit_en = 1'b1;
        bit_in = b;
        if (set_code) rate_sel = code;
        for (int g = 1; g < GAP; g++) begin
            @(negedge clk);
            bit_en = 1'b0;
            bit_in = 1'($urandom);
        end
    endtask

    // Queue expectations, then drive a segment at one rate and pattern.
    task automatic run_seg(input logic [1:0] code, input int pat, input int nout,
                           input bit change, input int extra);
        int n;
        int idx;
        n = 32 << code;
        for (int i = 0; i < nout; i++) begin
            exp_t e;
            e.settled = (i >= 3);
            e.value   = pat_value(pat);
            e.tag     = (pat <= 1) ? "R5/R2" : "R4/R2";
            exp_q.push_back(e);
            pushed++;
        end
        idx = 0;
        if (change) begin
            send_bit(pat_bit(pat, idx), 1'b1, code);
            idx++;
        end
        for (int i = 0; i < nout * n + extra; i++) begin
            send_bit(pat_bit(pat, idx), 1'b0, code);
            idx++;
        end
        repeat (GAP) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] code);
        @(negedge clk);
        rst_n = 1'b0;
        bit_en = 1'b0;
        rate_sel = code;
        repeat (3) @(negedge clk);
        check(sample_valid == 1'b0, "R1 valid in reset", int'(sample_valid), 0);
        check(sample_out == '0, "R1 sample in reset", int'(sample_out), 0);
        check(sample_settled == 1'b0, "R1 settled in reset", int'(sample_settled), 0);
        rst_n = 1'b1;
    endtask

    // Monitor: pop and compare each presented sample.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sample_valid && prev_valid) begin
                check(1'b0, "R3 valid longer than one clock", 1, 0);
            end
            if (sample_valid) begin
                seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3/R8 unexpected output", int'($signed(sample_out)), 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(sample_settled == e.settled, "R7 settled flag",
                          int'(sample_settled), int'(e.settled));
                    if (e.settled) begin
                        check(int'($signed(sample_out)) == e.value, e.tag,
                              int'($signed(sample_out)), e.value);
                    end
                end
            end
        end
        prev_valid = sample_valid;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset(2'd0);
        // R5 R3 R7: full-scale positive at N=32 clips.
        run_seg(2'd0, 0, 6, 1'b0, 0);
        // R6 R5: change to N=64, full-scale negative.
        run_seg(2'd1, 1, 5, 1'b1, 0);
        // R4: N=128, 3/4 density; end one bit short of a period.
        run_seg(2'd2, 2, 5, 1'b1, 127);
        // R8: change lands on the period-completing bit; N=256 follows.
        run_seg(2'd3, 3, 5, 1'b1, 0);
        // R4: back to N=32 with 5/8 density.
        run_seg(2'd0, 5, 6, 1'b1, 0);
        // R4: N=64, alternating input.
        run_seg(2'd1, 4, 5, 1'b1, 0);
        // R1 R7: reset mid-run, then N=128 with 5/8 density.
        do_reset(2'd2);
        run_seg(2'd2, 5, 5, 1'b0, 0);
        repeat (10) @(negedge clk);
        check(seen == pushed, "R3/R8 output count", seen, pushed);
        check(exp_q.size() == 0, "R3/R8 missing outputs", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule